// File: doc/BRIEF.md
# Dual Comparator Fault Supervisor

This block takes the digital results of two threshold comparators and turns them into one active-low fault indication. Each channel treats its comparator either as an undervoltage watch or as an overvoltage watch. One configuration bit hides the fault while the supply is being margined. The fault output is modelled as an open-drain enable: 1 pulls the line low, and 0 releases it.

A second function freezes the comparator states for later readback. When the ready line is configured active high and an external device pulls it low, the block captures the current comparator states in a status register. They stay there until software clears them. A small register port gives access to the configuration, the frozen states and the live states. A write-protect input guards the configuration against change.

Top module: `dual_comp_fault_sup`

## Requirements
- R1: A comparator bit of 1 means the monitored input is above its threshold. Configuration register (address 0) bit c selects the mode of channel c. In mode 0 (undervoltage), the channel is in fault when its comparator bit is 0. In mode 1 (overvoltage), the channel is in fault when its comparator bit is 1.
- R2: `fault_oe` is 1 when at least one channel is in fault and 0 otherwise. A change on `cmp_in` reaches `fault_oe` within three clock edges.
- R3: When configuration bit 2 (mask) is 1 and `margin_active` is 1, `fault_oe` is 0 whatever the channel states. With mask 0, `margin_active` has no effect.
- R4: When configuration bit 3 (ready active-high) is 1, a falling edge of the synchronized `rdy_sense` copies the synchronized comparator bits into status register (address 1) bits [1:0] and sets status bit 2 (snapshot valid).
- R5: A rising edge of `rdy_sense` never captures. A falling edge does not capture while configuration bit 3 is 0.
- R6: A captured snapshot holds while the comparators change. Writing status address 1 with bit 7 set clears the snapshot and the valid bit. If a capture and a clear fall in the same cycle, the capture wins.
- R7: While `wp_n` is 0, writes to the configuration register are ignored. The snapshot clear still works.
- R8: While `rst` is high, `fault_oe` is 0, and configuration, snapshot and `rd_data` return to 0.
- R9: `rd_data` is registered and shows the register selected by `rd_addr` one clock later. Address 2 returns the synchronized comparator bits in [1:0] and the per-channel fault flags in [3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | NUM_CH | Comparator results, 1 = input above threshold |
| margin_active | input | 1 | Margining in progress |
| rdy_sense | input | 1 | Sensed level of the ready line |
| wp_n | input | 1 | Write protect, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| fault_oe | output | 1 | Fault pull-down enable, 1 = drive low |

## Verification
The bench uses the default parameters: two channels, two synchronizer stages and eight-bit registers. Two channels are enough to reach every mixed-mode pairing, where one channel watches for undervoltage and the other for overvoltage. With an eight-bit data width, the clear bit (bit 7) is kept apart from the snapshot bits. Because the synchronizer has two stages, the bench knows the latency of both the fault path and the capture path, and samples after that many edges.

// File: rtl/dcfs_pkg.sv
package dcfs_pkg;
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_LIVE = 2;
endpackage

// File: rtl/dcfs_sync.sv
module dcfs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfs_chan_eval.sv
module dcfs_chan_eval #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] cmp_s,
  input  logic [NUM_CH-1:0] ov_mode,
  output logic [NUM_CH-1:0] flt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // overvoltage: fault when above; undervoltage: fault when below
    assign flt[c] = ov_mode[c] ? cmp_s[c] : ~cmp_s[c];
  end
endmodule

// File: rtl/dcfs_cfg.sv
module dcfs_cfg #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic              wp_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] ov_mode,
  output logic              mask_en,
  output logic              rdy_hi,
  output logic [DATA_W-1:0] cfg_rd
);
  localparam int CFG_W = NUM_CH + 2;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)                 cfg_q <= '0;
    else if (wr_cfg && wp_n) cfg_q <= wr_data[CFG_W-1:0];
  end

  assign ov_mode = cfg_q[NUM_CH-1:0];
  assign mask_en = cfg_q[NUM_CH];
  assign rdy_hi  = cfg_q[NUM_CH+1];
  assign cfg_rd  = DATA_W'(cfg_q);
endmodule

// File: rtl/dcfs_snap.sv
module dcfs_snap #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_s,
  input  logic              arm,
  input  logic              clr,
  input  logic [NUM_CH-1:0] cmp_s,
  output logic [NUM_CH-1:0] snap,
  output logic              snap_vld,
  output logic              rdy_fall
);
  logic rdy_d;

  always_ff @(posedge clk) begin
    if (rst) rdy_d <= 1'b0;
    else     rdy_d <= rdy_s;
  end

  assign rdy_fall = rdy_d & ~rdy_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap     <= '0;
      snap_vld <= 1'b0;
    end else if (rdy_fall && arm) begin
      snap     <= cmp_s;
      snap_vld <= 1'b1;
    end else if (clr) begin
      snap     <= '0;
      snap_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_comp_fault_sup.sv
module dual_comp_fault_sup
  import dcfs_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cmp_in,
  input  logic              margin_active,
  input  logic              rdy_sense,
  input  logic              wp_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault_oe
);
  localparam int CLR_BIT = DATA_W - 1;

  logic [NUM_CH-1:0] cmp_s, ov_mode, flt, snap;
  logic              mask_en, rdy_hi, rdy_s, snap_vld, rdy_fall, snap_clr, wr_cfg;
  logic [DATA_W-1:0] cfg_rd, rd_nxt;

  dcfs_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk(clk), .rst(rst), .d(cmp_in), .q(cmp_s));

  dcfs_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst(rst), .d(rdy_sense), .q(rdy_s));

  assign wr_cfg   = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
  assign snap_clr = wr_en && (wr_addr == ADDR_W'(ADDR_STAT)) && wr_data[CLR_BIT];

  dcfs_cfg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wp_n(wp_n), .wr_data(wr_data),
    .ov_mode(ov_mode), .mask_en(mask_en), .rdy_hi(rdy_hi), .cfg_rd(cfg_rd));

  dcfs_chan_eval #(.NUM_CH(NUM_CH)) u_eval (
    .cmp_s(cmp_s), .ov_mode(ov_mode), .flt(flt));

  dcfs_snap #(.NUM_CH(NUM_CH)) u_snap (
    .clk(clk), .rst(rst), .rdy_s(rdy_s), .arm(rdy_hi), .clr(snap_clr),
    .cmp_s(cmp_s), .snap(snap), .snap_vld(snap_vld), .rdy_fall(rdy_fall));

  always_ff @(posedge clk) begin
    if (rst) fault_oe <= 1'b0;
    else     fault_oe <= (|flt) && !(mask_en && margin_active);
  end

  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      ADDR_W'(ADDR_CFG):  rd_nxt = cfg_rd;
      ADDR_W'(ADDR_STAT): begin
        rd_nxt[NUM_CH-1:0] = snap;
        rd_nxt[NUM_CH]     = snap_vld;
      end
      ADDR_W'(ADDR_LIVE): begin
        rd_nxt[NUM_CH-1:0]        = cmp_s;
        rd_nxt[2*NUM_CH-1:NUM_CH] = flt;
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/dcfs_chk.sv
module dcfs_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              margin_active,
  input logic              mask_en,
  input logic              rdy_hi,
  input logic              rdy_fall,
  input logic              snap_vld,
  input logic              snap_clr,
  input logic              wr_cfg,
  input logic              wp_n,
  input logic [NUM_CH-1:0] flt,
  input logic [NUM_CH-1:0] ov_mode,
  input logic              fault_oe
);
  // R3
  mask_hides_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_en && margin_active) |=> !fault_oe);

  // R2
  any_fault_drives_chk: assert property (@(posedge clk) disable iff (rst)
    ((|flt) && !(mask_en && margin_active)) |=> fault_oe);

  // R4
  capture_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_fall && rdy_hi) |=> snap_vld);

  // R6
  snapshot_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (snap_vld && !snap_clr) |=> snap_vld);

  // R7
  protect_blocks_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !wp_n) |=> ($stable(ov_mode) && $stable(mask_en) && $stable(rdy_hi)));
endmodule

bind dual_comp_fault_sup dcfs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .margin_active(margin_active), .mask_en(mask_en),
  .rdy_hi(rdy_hi), .rdy_fall(rdy_fall), .snap_vld(snap_vld), .snap_clr(snap_clr),
  .wr_cfg(wr_cfg), .wp_n(wp_n), .flt(flt), .ov_mode(ov_mode), .fault_oe(fault_oe));

// File: tb/tb_dual_comp_fault_sup.sv
module tb_dual_comp_fault_sup;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmp_in = 2'b11;
  logic       margin_active = 1'b0;
  logic       rdy_sense = 1'b0;
  logic       wp_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       fault_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dual_comp_fault_sup dut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .margin_active(margin_active),
    .rdy_sense(rdy_sense), .wp_n(wp_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fault_oe(fault_oe));

  // vector: {mode1, mode0, mask, margin, cmp1, cmp0, expected fault_oe}
  localparam logic [6:0] VEC [12] = '{
    7'b00_0_0_11_0, 7'b00_0_0_10_1, 7'b00_0_0_01_1, 7'b11_0_0_00_0,
    7'b11_0_0_01_1, 7'b01_0_0_10_0, 7'b01_0_0_11_1, 7'b01_0_0_00_1,
    7'b00_1_1_00_0, 7'b00_1_0_00_1, 7'b00_0_1_00_1, 7'b10_1_1_11_0
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk("R8 fault released in reset", {7'b0, fault_oe}, 8'h00);
    chk("R8 rd_data cleared in reset", rd_data, 8'h00);
    rst = 1'b0;
    settle();
    rd(2'd0, r); chk("R8 cfg after reset", r, 8'h00);
    rd(2'd1, r); chk("R8 status after reset", r, 8'h00);
    chk("R2 no fault with inputs above", {7'b0, fault_oe}, 8'h00);

    // R1 R2 R3 table walk
    for (int i = 0; i < 12; i++) begin
      wr(2'd0, {4'b0, VEC[i][4], VEC[i][6:5]});
      margin_active = VEC[i][3];
      cmp_in = VEC[i][2:1];
      settle();
      chk($sformatf("R1 R2 R3 vector %0d", i), {7'b0, fault_oe}, {7'b0, VEC[i][0]});
    end
    margin_active = 1'b0;

    // R9 live view: UV both, cmp=01 -> ch1 in fault
    wr(2'd0, 8'h00);
    cmp_in = 2'b01;
    settle();
    rd(2'd2, r); chk("R9 live register", r, 8'h09);

    // R7 write protect
    wp_n = 1'b0;
    wr(2'd0, 8'h03);
    settle();
    rd(2'd0, r); chk("R7 cfg unchanged under protect", r, 8'h00);
    chk("R7 fault mode unchanged", {7'b0, fault_oe}, 8'h01);
    wp_n = 1'b1;

    // R4 capture on falling edge, ready active high
    wr(2'd0, 8'h08);
    cmp_in = 2'b10;
    rdy_sense = 1'b1;
    settle();
    rd(2'd1, r); chk("R5 rising edge no capture", r, 8'h00);
    rdy_sense = 1'b0;
    settle();
    rd(2'd1, r); chk("R4 snapshot captured", r, 8'h06);

    // R6 hold
    cmp_in = 2'b01;
    rdy_sense = 1'b1;
    settle();
    rd(2'd1, r); chk("R6 snapshot holds", r, 8'h06);

    // R6 R7 clear works under protect
    wp_n = 1'b0;
    wr(2'd1, 8'h80);
    wp_n = 1'b1;
    rd(2'd1, r); chk("R6 R7 clear under protect", r, 8'h00);

    // R5 no capture with ready active low
    wr(2'd0, 8'h00);
    rdy_sense = 1'b1;
    settle();
    rdy_sense = 1'b0;
    settle();
    rd(2'd1, r); chk("R5 no capture when active low", r, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule